// File: doc/BRIEF.md
# Memory Latency Configuration Sequencer

This block runs the one-time latency set-up of a DDR pseudo-static RAM controller after power-up. A single start pulse makes it take the system clock frequency (in Hz) and a flag from the controller that says variable latency is available. It treats one quarter of the system frequency as the memory clock and maps that clock to a latency band. Each band gives two encodings: a plain cycle count for the controller and a 4-bit code for the memory device.

The sequencer first hands the cycle count to the controller configuration output. It then builds the value for the device's configuration register 0. The value starts from a fixed default. The latency field is patched with the device code, and the fixed-latency bit is cleared when the controller flag is set. The sequencer writes this value to register address 2 through a request/done register-access port. It then reads the same address back, keeps the returned word and signals completion with a one-cycle pulse. The bus protocol behind the register-access port belongs to another block.

Top module: `lat_cfg_seq`

## Requirements
- R1: With mem = floor(sys_freq_hz / 4), `cfg_lat` becomes 3 for mem ≤ 85 000 000, 4 for mem ≤ 104 000 000, 5 for mem ≤ 133 000 000, 6 for mem ≤ 166 000 000 and 7 for mem ≤ 250 000 000. Every bound is inclusive, and any larger mem gives 7.
- R2: Bits 7:4 of the written register word hold the device code for the same bands: 4'b1110, 4'b1111, 4'b0000, 4'b0001, 4'b0010, with 4'b0010 above the last bound.
- R3: The written word is 16'h8F2F with bits 7:4 replaced as in R2. Bit 3 is cleared when `var_lat_ok` was high at start and is left at 1 otherwise. All other bits keep their default values.
- R4: `cfg_lat` holds the new count, and `cfg_lat_we` has pulsed, before `reg_wr_req` first rises.
- R5: `reg_wdata` carries the word and `reg_addr` equals 2 at least one cycle before `reg_wr_req` rises. `reg_wr_req` then stays high until the cycle in which `reg_wr_done` is sampled high.
- R6: In the cycle after the write is acknowledged, `reg_rd_req` rises with `reg_addr` = 2 and stays high until `reg_rd_done` is sampled. `reg_wr_req` and `reg_rd_req` are never high together.
- R7: `reg_rdata` is captured into `readback` on the edge where `reg_rd_done` is seen. `done` is high for exactly the following cycle, and `busy` is low after that.
- R8: A `start` pulse that arrives while `busy` is high is ignored: no second sequence follows.
- R9: A synchronous active-high `rst` returns the block to idle and clears `cfg_lat`, `readback`, `reg_wdata`, both requests, `done` and `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that launches the sequence |
| sys_freq_hz | input | FREQ_W | System clock frequency in Hz, sampled at start |
| var_lat_ok | input | 1 | Controller supports variable latency, sampled at start |
| cfg_lat | output | 3 | Latency count for the controller configuration |
| cfg_lat_we | output | 1 | One-cycle strobe when cfg_lat is updated |
| reg_wdata | output | REG_W | Data for the register write |
| reg_addr | output | ADDR_W | Register address for the access |
| reg_wr_req | output | 1 | Register write request, held until acknowledged |
| reg_rd_req | output | 1 | Register read request, held until acknowledged |
| reg_wr_done | input | 1 | Write completion indication |
| reg_rd_done | input | 1 | Read completion indication |
| reg_rdata | input | REG_W | Read data, valid with reg_rd_done |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| readback | output | REG_W | Captured configuration register value |

## Verification
The checker assumes that `reg_wr_done` and `reg_rd_done` arrive only while the matching request is high. It also assumes that `reg_rdata` is valid in the cycle that `reg_rd_done` is high. The stimulus follows this: it acts as the register responder itself and raises each completion only after it has seen the request. The acknowledge delay and the returned data vary from run to run. The frequency sweep covers every band edge on both sides, including the sub-4 Hz remainder that the divide by four drops. Each edge is run with the variable-latency flag both low and high. Extra start pulses are sent while the block is busy to cover R8.

// File: rtl/lat_cfg_pkg.sv
package lat_cfg_pkg;

    localparam int NBANDS      = 5;
    localparam int LAT_W       = 3;
    localparam int CODE_W      = 4;
    localparam int CODE_LSB    = 4;
    localparam int FIXLAT_BIT  = 3;
    localparam logic [15:0] CFG0_DEFAULT = 16'h8F2F;
    localparam int CFG0_ADDR   = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CALC,
        ST_WDATA,
        ST_WREQ,
        ST_RREQ,
        ST_FIN
    } seq_state_e;

    typedef struct packed {
        logic [LAT_W-1:0]  lat;
        logic [CODE_W-1:0] code;
    } band_sel_t;

    // Upper inclusive memory-clock bound of a band, in Hz
    function automatic logic [63:0] band_limit_hz(input int idx);
        case (idx)
            0:       band_limit_hz = 64'd85_000_000;
            1:       band_limit_hz = 64'd104_000_000;
            2:       band_limit_hz = 64'd133_000_000;
            3:       band_limit_hz = 64'd166_000_000;
            default: band_limit_hz = 64'd250_000_000;
        endcase
    endfunction

    function automatic logic [LAT_W-1:0] band_lat(input logic [2:0] idx);
        case (idx)
            3'd0:    band_lat = 3'd3;
            3'd1:    band_lat = 3'd4;
            3'd2:    band_lat = 3'd5;
            3'd3:    band_lat = 3'd6;
            default: band_lat = 3'd7;
        endcase
    endfunction

    function automatic logic [CODE_W-1:0] band_code(input logic [2:0] idx);
        case (idx)
            3'd0:    band_code = 4'b1110;
            3'd1:    band_code = 4'b1111;
            3'd2:    band_code = 4'b0000;
            3'd3:    band_code = 4'b0001;
            default: band_code = 4'b0010;
        endcase
    endfunction

endpackage

// File: rtl/lat_band_select.sv
module lat_band_select
    import lat_cfg_pkg::*;
#(
    parameter int FREQ_W = 32
) (
    input  logic [FREQ_W-1:0] sys_freq,
    output band_sel_t         sel
);

    localparam int DIV_SHIFT = 2;

    logic [FREQ_W-1:0] mem_freq;
    logic [NBANDS-1:0] hit;
    logic [2:0]        idx;

    assign mem_freq = sys_freq >> DIV_SHIFT;

    generate
        for (genvar gi = 0; gi < NBANDS; gi++) begin : g_band
            assign hit[gi] = (64'(mem_freq) <= band_limit_hz(gi));
        end
    endgenerate

    // lowest band whose bound is not exceeded wins; none -> top band
    always_comb begin
        idx = 3'(NBANDS - 1);
        for (int i = NBANDS - 1; i >= 0; i--) begin
            if (hit[i]) idx = 3'(i);
        end
        sel.lat  = band_lat(idx);
        sel.code = band_code(idx);
    end

endmodule

// File: rtl/cfg_word_build.sv
module cfg_word_build
    import lat_cfg_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic [CODE_W-1:0] code,
    input  logic              var_lat,
    output logic [REG_W-1:0]  word
);

    always_comb begin
        word = REG_W'(CFG0_DEFAULT);
        if (var_lat) word[FIXLAT_BIT] = 1'b0;
        word[CODE_LSB +: CODE_W] = code;
    end

endmodule

// File: rtl/lat_cfg_ctrl.sv
module lat_cfg_ctrl
    import lat_cfg_pkg::*;
#(
    parameter int FREQ_W = 32,
    parameter int REG_W  = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [FREQ_W-1:0] sys_freq_hz,
    input  logic              var_lat_ok,
    output logic [FREQ_W-1:0] freq_q,
    output logic              var_q,
    input  band_sel_t         sel,
    input  logic [REG_W-1:0]  word,
    output logic [LAT_W-1:0]  cfg_lat,
    output logic              cfg_lat_we,
    output logic [REG_W-1:0]  reg_wdata,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr_req,
    output logic              reg_rd_req,
    input  logic              reg_wr_done,
    input  logic              reg_rd_done,
    input  logic [REG_W-1:0]  reg_rdata,
    output logic [REG_W-1:0]  readback,
    output logic              done,
    output logic              busy
);

    seq_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:  if (start) state_nx = ST_CALC;
            ST_CALC:  state_nx = ST_WDATA;
            ST_WDATA: state_nx = ST_WREQ;
            ST_WREQ:  if (reg_wr_done) state_nx = ST_RREQ;
            ST_RREQ:  if (reg_rd_done) state_nx = ST_FIN;
            ST_FIN:   state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            freq_q     <= '0;
            var_q      <= 1'b0;
            cfg_lat    <= '0;
            cfg_lat_we <= 1'b0;
            reg_wdata  <= '0;
            reg_addr   <= '0;
            readback   <= '0;
        end else begin
            state      <= state_nx;
            cfg_lat_we <= 1'b0;
            if (state == ST_IDLE && start) begin
                freq_q <= sys_freq_hz;
                var_q  <= var_lat_ok;
            end
            if (state == ST_CALC) begin
                cfg_lat    <= sel.lat;
                cfg_lat_we <= 1'b1;
                reg_wdata  <= word;
                reg_addr   <= ADDR_W'(CFG0_ADDR);
            end
            if (state == ST_RREQ && reg_rd_done) begin
                readback <= reg_rdata;
            end
        end
    end

    assign reg_wr_req = (state == ST_WREQ);
    assign reg_rd_req = (state == ST_RREQ);
    assign done       = (state == ST_FIN);
    assign busy       = (state != ST_IDLE);

endmodule

// File: rtl/lat_cfg_seq.sv
module lat_cfg_seq
    import lat_cfg_pkg::*;
#(
    parameter int FREQ_W = 32,
    parameter int REG_W  = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [FREQ_W-1:0] sys_freq_hz,
    input  logic              var_lat_ok,
    output logic [2:0]        cfg_lat,
    output logic              cfg_lat_we,
    output logic [REG_W-1:0]  reg_wdata,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr_req,
    output logic              reg_rd_req,
    input  logic              reg_wr_done,
    input  logic              reg_rd_done,
    input  logic [REG_W-1:0]  reg_rdata,
    output logic              busy,
    output logic              done,
    output logic [REG_W-1:0]  readback
);

    logic [FREQ_W-1:0] freq_q;
    logic              var_q;
    band_sel_t         sel;
    logic [REG_W-1:0]  word;

    lat_band_select #(.FREQ_W(FREQ_W)) u_band (
        .sys_freq (freq_q),
        .sel      (sel)
    );

    cfg_word_build #(.REG_W(REG_W)) u_word (
        .code    (sel.code),
        .var_lat (var_q),
        .word    (word)
    );

    lat_cfg_ctrl #(.FREQ_W(FREQ_W), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .sys_freq_hz (sys_freq_hz),
        .var_lat_ok  (var_lat_ok),
        .freq_q      (freq_q),
        .var_q       (var_q),
        .sel         (sel),
        .word        (word),
        .cfg_lat     (cfg_lat),
        .cfg_lat_we  (cfg_lat_we),
        .reg_wdata   (reg_wdata),
        .reg_addr    (reg_addr),
        .reg_wr_req  (reg_wr_req),
        .reg_rd_req  (reg_rd_req),
        .reg_wr_done (reg_wr_done),
        .reg_rd_done (reg_rd_done),
        .reg_rdata   (reg_rdata),
        .readback    (readback),
        .done        (done),
        .busy        (busy)
    );

endmodule

// File: rtl/lat_cfg_chk.sv
module lat_cfg_chk #(
    parameter int REG_W  = 16,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        cfg_lat,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr_req,
    input logic              reg_rd_req,
    input logic              reg_wr_done,
    input logic              reg_rd_done,
    input logic              busy,
    input logic              done
);

    // R6
    req_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr_req && reg_rd_req));

    // R5
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_req && !reg_wr_done) |=> reg_wr_req);

    // R6
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_req && !reg_rd_done) |=> reg_rd_req);

    // R6
    rd_after_wr_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(reg_rd_req) |-> $past(reg_wr_done));

    // R4
    lat_before_wr_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(reg_wr_req) |-> (cfg_lat >= 3'd3));

    // R5
    addr_during_req_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_req || reg_rd_req) |-> (reg_addr == ADDR_W'(2)));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    done_after_rd_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(reg_rd_done));

    // R7
    idle_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

endmodule

bind lat_cfg_seq lat_cfg_chk #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_lat_cfg_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_lat     (cfg_lat),
    .reg_addr    (reg_addr),
    .reg_wr_req  (reg_wr_req),
    .reg_rd_req  (reg_rd_req),
    .reg_wr_done (reg_wr_done),
    .reg_rd_done (reg_rd_done),
    .busy        (busy),
    .done        (done)
);

// File: tb/test_lat_cfg_seq.sv
`timescale 1ns/1ps
module test_lat_cfg_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] sys_freq_hz = '0;
    logic        var_lat_ok = 1'b0;
    logic [2:0]  cfg_lat;
    logic        cfg_lat_we;
    logic [15:0] reg_wdata;
    logic [7:0]  reg_addr;
    logic        reg_wr_req, reg_rd_req;
    logic        reg_wr_done = 1'b0;
    logic        reg_rd_done = 1'b0;
    logic [15:0] reg_rdata = '0;
    logic        busy, done;
    logic [15:0] readback;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    lat_cfg_seq i_lat_cfg_seq (
        .clk(clk), .rst(rst), .start(start), .sys_freq_hz(sys_freq_hz),
        .var_lat_ok(var_lat_ok), .cfg_lat(cfg_lat), .cfg_lat_we(cfg_lat_we),
        .reg_wdata(reg_wdata), .reg_addr(reg_addr), .reg_wr_req(reg_wr_req),
        .reg_rd_req(reg_rd_req), .reg_wr_done(reg_wr_done), .reg_rd_done(reg_rd_done),
        .reg_rdata(reg_rdata), .busy(busy), .done(done), .readback(readback)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int band_of(input logic [31:0] f);
        longint m;
        m = longint'(f) / 4;
        if (m <= 85_000_000)  return 0;
        if (m <= 104_000_000) return 1;
        if (m <= 133_000_000) return 2;
        if (m <= 166_000_000) return 3;
        return 4;
    endfunction

    function automatic logic [15:0] exp_word(input logic [31:0] f, input logic v);
        logic [15:0] w;
        logic [3:0]  c;
        c = 4'((band_of(f) + 14) % 16);
        w = 16'h8F2F;
        if (v) w[3] = 1'b0;
        w[7:4] = c;
        return w;
    endfunction

    task automatic run_case(input logic [31:0] f, input logic v, input int wdly,
                            input int rdly, input bit flip, input bit poke);
        logic [2:0]  el;
        logic [15:0] ew, mem, rb, last_wd;
        bit saw_we;
        int n;
        el = 3'(3 + band_of(f));
        ew = exp_word(f, v);
        @(negedge clk);
        sys_freq_hz = f; var_lat_ok = v; start = 1'b1;
        @(negedge clk);
        start = 1'b0; sys_freq_hz = '0; var_lat_ok = ~v;
        saw_we = 0; n = 0; last_wd = reg_wdata;
        while (!reg_wr_req && n < 50) begin
            if (cfg_lat_we) saw_we = 1;
            last_wd = reg_wdata;
            @(negedge clk);
            n++;
        end
        chk(reg_wr_req, "R5 write request raised", 32'(reg_wr_req), 1);
        chk(saw_we, "R4 cfg strobe before write", 32'(saw_we), 1);
        chk(cfg_lat == el, "R1 latency count", 32'(cfg_lat), 32'(el));
        chk(reg_wdata[7:4] == ew[7:4], "R2 chip code", 32'(reg_wdata[7:4]), 32'(ew[7:4]));
        chk(reg_wdata == ew, "R3 register word", 32'(reg_wdata), 32'(ew));
        chk(last_wd == ew, "R5 data before request", 32'(last_wd), 32'(ew));
        chk(reg_addr == 8'd2, "R5 write address", 32'(reg_addr), 2);
        chk(!reg_rd_req, "R6 no read during write", 32'(reg_rd_req), 0);
        for (int k = 0; k < wdly; k++) begin
            start = poke;
            @(negedge clk);
            start = 1'b0;
            chk(reg_wr_req, "R5 write request held", 32'(reg_wr_req), 1);
        end
        mem = reg_wdata;
        reg_wr_done = 1'b1;
        @(negedge clk);
        reg_wr_done = 1'b0;
        chk(reg_rd_req && !reg_wr_req, "R6 read follows write", {30'd0, reg_wr_req, reg_rd_req}, 1);
        chk(reg_addr == 8'd2, "R6 read address", 32'(reg_addr), 2);
        for (int k = 0; k < rdly; k++) begin
            start = poke;
            @(negedge clk);
            start = 1'b0;
            chk(reg_rd_req, "R6 read request held", 32'(reg_rd_req), 1);
        end
        rb = flip ? (mem ^ 16'h5AA5) : mem;
        reg_rdata = rb; reg_rd_done = 1'b1;
        chk(!done, "R7 no early done", 32'(done), 0);
        @(negedge clk);
        reg_rd_done = 1'b0; reg_rdata = 16'hDEAD;
        chk(done, "R7 done pulse", 32'(done), 1);
        chk(readback == rb, "R7 readback", 32'(readback), 32'(rb));
        chk(!reg_rd_req, "R7 read dropped", 32'(reg_rd_req), 0);
        @(negedge clk);
        chk(!done && !busy, "R7 back to idle", {30'd0, done, busy}, 0);
        if (poke) begin
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                chk(!busy && !reg_wr_req, "R8 busy start ignored", {30'd0, reg_wr_req, busy}, 0);
            end
        end
    endtask

    initial begin
        #(4 * 150_000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %h expected %h", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] lim;
        int idx;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk(!busy && !done && !reg_wr_req && !reg_rd_req, "R9 idle after reset",
            {28'd0, busy, done, reg_wr_req, reg_rd_req}, 0);
        chk(cfg_lat == 3'd0 && readback == 16'd0, "R9 outputs cleared",
            {13'd0, cfg_lat, readback}, 0);
        idx = 0;
        for (int b = 0; b < 5; b++) begin
            case (b)
                0: lim = 32'd85_000_000;
                1: lim = 32'd104_000_000;
                2: lim = 32'd133_000_000;
                3: lim = 32'd166_000_000;
                default: lim = 32'd250_000_000;
            endcase
            for (int o = 0; o < 3; o++) begin
                for (int v = 0; v < 2; v++) begin
                    run_case(4 * lim + ((o == 0) ? 32'd0 : (o == 1) ? 32'd3 : 32'd4),
                             v[0], idx % 4, (idx + 1) % 3, idx[0], (idx % 5) == 2);
                    idx++;
                end
            end
        end
        run_case(32'd0, 1'b1, 0, 0, 1'b0, 1'b0);
        run_case(32'd0, 1'b0, 2, 1, 1'b1, 1'b1);
        run_case(32'hFFFF_FFFF, 1'b0, 1, 2, 1'b0, 1'b0);
        run_case(32'hFFFF_FFFF, 1'b1, 3, 0, 1'b1, 1'b1);
        // R9 reset in mid-sequence
        @(negedge clk);
        sys_freq_hz = 32'd400_000_000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        chk(reg_wr_req, "R9 parked in write", 32'(reg_wr_req), 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(!busy && !reg_wr_req && !reg_rd_req && !done, "R9 reset to idle",
            {28'd0, busy, done, reg_wr_req, reg_rd_req}, 0);
        chk(cfg_lat == 3'd0 && readback == 16'd0 && reg_wdata == 16'd0, "R9 reset clears",
            {cfg_lat, readback[12:0], reg_wdata}, 0);
        repeat (3) @(negedge clk);
        chk(!busy, "R9 stays idle", 32'(busy), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule